// File: doc/BRIEF.md
# Wish Branch Fetch-Mode and Recovery Controller

This front-end block decides, for every branch the fetch stage presents, whether fetch follows the branch predictor or runs through the code on a predicate. A wish branch whose prediction is trusted behaves like an ordinary conditional branch. An untrusted wish jump turns its if/else region into predicated code: fetch goes down the fall-through path through both arms, and neither the jump nor its matching wish join can cause a flush. An untrusted wish loop keeps following the predictor, but the block notes how many further iterations of the same loop were fetched after each one. A loop that overshoots its exit (late exit) is then absorbed without a flush, while stopping too early (early exit) or never fetching the exit (no exit) both force a redirect.

Fetch presents each branch with a slot tag chosen by the surrounding front end, its kind, predicted direction, confidence bit and the two candidate addresses. Later the core resolves the slot with the actual outcome. A flush is a one-cycle pulse with the redirect address, raised in the cycle after the resolution that causes it. It empties every tracked slot and leaves predicated mode.

Top module: `wish_fetch_ctrl`

## Requirements
- R1: After reset `flush` and `pred_mode` are 0 and no slot is tracked, so a resolution on any slot gives no flush.
- R2: Branch kind encoding is 2'b00 normal, 2'b01 wish jump, 2'b10 wish join, 2'b11 wish loop. For a normal branch `fet_taken` equals `fet_pred` whatever `fet_conf_hi` is. Its resolution raises `flush` in the next cycle exactly when the actual outcome differs from the prediction. `redirect_pc` is then the target address if the branch was actually taken, otherwise the fall-through address.
- R3: A wish jump or wish loop fetched with `fet_conf_hi`=1 (and, for a jump, with `pred_mode`=0) behaves exactly as in R2.
- R4: A wish jump fetched with `fet_conf_hi`=0 while `pred_mode`=0 gives `fet_taken`=0 and `fet_predicated`=1. It sets `pred_mode` from the next cycle, and its resolution never flushes.
- R5: A wish join fetched while `pred_mode`=1 gives `fet_taken`=0 and `fet_predicated`=1, clears `pred_mode` from the next cycle, and never flushes. A wish join fetched while `pred_mode`=0 behaves as in R2.
- R6: A wish jump fetched while `pred_mode`=1, whatever its confidence, is forced not-taken and never flushes, and `pred_mode` stays 1. The first wish join then clears it.
- R7: Early exit: a wish loop fetched with `fet_conf_hi`=0 and predicted not-taken that resolves taken flushes to its target (the loop body).
- R8: Late exit: a low-confidence wish loop predicted taken that resolves not-taken gives no flush if at least one later low-confidence wish loop with the same target was fetched after it and that chain included a not-taken fetch. All tracked low-confidence loops with that target are dropped, so their later resolutions give no flush.
- R9: No exit: the same loop as in R8 resolving not-taken with no not-taken fetch of that loop since it flushes to its fall-through (exit) address.
- R10: A flush clears `pred_mode` and every tracked slot. A fetch presented in the same cycle as a flushing resolution is discarded and its slot gives no flush when later resolved.
- R11: `flush` is never high in two consecutive cycles, and a resolution on a slot that holds nothing gives no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fet_valid | input | 1 | A branch is presented by fetch this cycle |
| fet_kind | input | 2 | Branch kind (encoding in R2) |
| fet_pred | input | 1 | Predicted direction, 1 = taken |
| fet_conf_hi | input | 1 | Confidence of the prediction, 1 = high |
| fet_tag | input | TAG_W | Slot the branch is tracked in |
| fet_tgt_pc | input | PC_W | Taken-path address |
| fet_fall_pc | input | PC_W | Not-taken-path address |
| res_valid | input | 1 | A resolution is presented this cycle |
| res_tag | input | TAG_W | Slot being resolved |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| fet_taken | output | 1 | Direction fetch must follow for the presented branch |
| fet_predicated | output | 1 | The presented branch is handled in low-confidence fashion |
| pred_mode | output | 1 | Fetch is inside a predicated region |
| flush | output | 1 | One-cycle flush request |
| redirect_pc | output | PC_W | Address fetch restarts from, valid with `flush` |

## Verification
`fet_taken` and `fet_predicated` are combinational in the presented branch and the current `pred_mode`. They are checked in the same cycle, shortly after the inputs change at the falling edge. `pred_mode`, `flush` and `redirect_pc` change on the first rising edge after the fetch or resolution that causes them, so they are compared at the falling edge that follows. The reference model steps on each rising edge from the inputs held over it, and its registered values are compared every cycle, including idle ones, which is how the one-cycle pulse and the absence of flushes on absorbed resolutions are observed.

// File: rtl/wish_pkg.sv
package wish_pkg;

  typedef enum logic [1:0] {
    BK_NORMAL = 2'b00,
    BK_JUMP   = 2'b01,
    BK_JOIN   = 2'b10,
    BK_LOOP   = 2'b11
  } br_kind_e;

  typedef enum logic [1:0] {
    RO_NONE,
    RO_FLUSH_TGT,
    RO_FLUSH_FALL,
    RO_LATE
  } res_out_e;

  // tracked per in-flight branch
  typedef struct packed {
    logic     valid;
    br_kind_e kind;
    logic     pred;
    logic     quiet;      // predicated jump/join: never flushes
    logic     loop_low;   // low-confidence loop
    logic     exit_seen;  // a not-taken fetch of this loop came later (or itself)
  } slot_meta_t;

  typedef struct packed {
    logic taken;
    logic low;
    logic set_mode;
    logic clr_mode;
  } fetch_dec_t;

  // fetch-side decision for a presented branch
  function automatic fetch_dec_t decide_fetch(br_kind_e kind, logic pred,
                                              logic conf_hi, logic mode);
    fetch_dec_t d;
    d       = '0;
    d.taken = pred;
    case (kind)
      BK_JUMP: begin
        if (mode || !conf_hi) begin
          d.taken    = 1'b0;
          d.low      = 1'b1;
          d.set_mode = !mode;
        end
      end
      BK_JOIN: begin
        if (mode) begin
          d.taken    = 1'b0;
          d.low      = 1'b1;
          d.clr_mode = 1'b1;
        end
      end
      BK_LOOP: d.low = !conf_hi;
      default: ;
    endcase
    return d;
  endfunction

  // resolution-side decision for a tracked slot
  function automatic res_out_e decide_resolve(slot_meta_t m, logic cnt_nz,
                                              logic actual);
    if (!m.valid || m.quiet) return RO_NONE;
    if (m.loop_low) begin
      if (actual && !m.pred) return RO_FLUSH_TGT;
      if (!actual && m.pred) return (m.exit_seen && cnt_nz) ? RO_LATE : RO_FLUSH_FALL;
      return RO_NONE;
    end
    if (actual != m.pred) return actual ? RO_FLUSH_TGT : RO_FLUSH_FALL;
    return RO_NONE;
  endfunction

endpackage

// File: rtl/wish_mode_flag.sv
module wish_mode_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic set_req,
  input  logic clr_req,
  output logic mode
);
  logic mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (kill)    mode_q <= 1'b0;
    else if (set_req) mode_q <= 1'b1;
    else if (clr_req) mode_q <= 1'b0;
  end

  assign mode = mode_q;

  // R10: a flush always leaves predicated mode
  p_kill_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !mode);

endmodule

// File: rtl/wish_slot_table.sv
module wish_slot_table
  import wish_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int PC_W  = 32,
  parameter int CNT_W = 3,
  localparam int TAG_W = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_idx,
  input  slot_meta_t       wr_meta,
  input  logic [PC_W-1:0]  wr_tgt,
  input  logic [PC_W-1:0]  wr_fall,
  input  logic             sib_en,
  input  logic [PC_W-1:0]  sib_tgt,
  input  logic             sib_exit,
  input  logic             sq_en,
  input  logic [PC_W-1:0]  sq_tgt,
  input  logic             fr_en,
  input  logic [TAG_W-1:0] fr_idx,
  input  logic [TAG_W-1:0] rd_idx,
  output slot_meta_t       rd_meta,
  output logic             rd_cnt_nz,
  output logic [PC_W-1:0]  rd_tgt,
  output logic [PC_W-1:0]  rd_fall
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  slot_meta_t             meta_q [NSLOT];
  logic [CNT_W-1:0]       cnt_q  [NSLOT];
  logic [PC_W-1:0]        tgt_q  [NSLOT];
  logic [PC_W-1:0]        fall_q [NSLOT];
  logic [NSLOT-1:0]       vld;

  function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic sib_hit, sq_hit, fr_hit, wr_hit;
    assign wr_hit  = wr_en && (wr_idx == TAG_W'(g));
    assign fr_hit  = fr_en && (fr_idx == TAG_W'(g));
    assign sq_hit  = sq_en && meta_q[g].valid && meta_q[g].loop_low && (tgt_q[g] == sq_tgt);
    assign sib_hit = sib_en && meta_q[g].valid && meta_q[g].loop_low &&
                     !meta_q[g].exit_seen && (tgt_q[g] == sib_tgt);
    assign vld[g]  = meta_q[g].valid;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q[g] <= '0;
        cnt_q[g]  <= '0;
        tgt_q[g]  <= '0;
        fall_q[g] <= '0;
      end else if (clear_all) begin
        meta_q[g].valid <= 1'b0;
      end else if (wr_hit) begin
        meta_q[g] <= wr_meta;
        cnt_q[g]  <= '0;
        tgt_q[g]  <= wr_tgt;
        fall_q[g] <= wr_fall;
      end else if (fr_hit || sq_hit) begin
        meta_q[g].valid <= 1'b0;
      end else if (sib_hit) begin
        cnt_q[g]            <= sat_inc(cnt_q[g]);
        meta_q[g].exit_seen <= sib_exit;
      end
    end
  end

  assign rd_meta   = meta_q[rd_idx];
  assign rd_cnt_nz = (cnt_q[rd_idx] != '0);
  assign rd_tgt    = tgt_q[rd_idx];
  assign rd_fall   = fall_q[rd_idx];

  // R10: a flush leaves nothing tracked
  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (vld == '0));

endmodule

// File: rtl/wish_resolve_unit.sv
module wish_resolve_unit
  import wish_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            res_valid,
  input  logic            res_taken,
  input  slot_meta_t      meta,
  input  logic            cnt_nz,
  input  logic [PC_W-1:0] tgt,
  input  logic [PC_W-1:0] fall,
  output logic            flush_now,
  output logic            late_now,
  output logic            flush_o,
  output logic [PC_W-1:0] redirect_o
);
  res_out_e outc;

  always_comb begin
    outc = RO_NONE;
    if (res_valid) outc = decide_resolve(meta, cnt_nz, res_taken);
  end

  assign flush_now = (outc == RO_FLUSH_TGT) || (outc == RO_FLUSH_FALL);
  assign late_now  = (outc == RO_LATE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_o    <= 1'b0;
      redirect_o <= '0;
    end else begin
      flush_o <= flush_now;
      if (flush_now) redirect_o <= (outc == RO_FLUSH_TGT) ? tgt : fall;
    end
  end

  // R4: predicated jump/join resolutions are absorbed
  p_quiet_no_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && meta.valid && meta.quiet) |=> !flush_o);

  // R7: early exit returns fetch to the loop body
  p_early_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && meta.valid && meta.loop_low && !meta.pred && res_taken)
      |=> (flush_o && redirect_o == $past(tgt)));

  // R11: the flush request lasts one cycle
  p_flush_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);

endmodule

// File: rtl/wish_fetch_ctrl.sv
module wish_fetch_ctrl
  import wish_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int PC_W  = 32,
  parameter int CNT_W = 3,
  localparam int TAG_W = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fet_valid,
  input  logic [1:0]       fet_kind,
  input  logic             fet_pred,
  input  logic             fet_conf_hi,
  input  logic [TAG_W-1:0] fet_tag,
  input  logic [PC_W-1:0]  fet_tgt_pc,
  input  logic [PC_W-1:0]  fet_fall_pc,
  input  logic             res_valid,
  input  logic [TAG_W-1:0] res_tag,
  input  logic             res_taken,
  output logic             fet_taken,
  output logic             fet_predicated,
  output logic             pred_mode,
  output logic             flush,
  output logic [PC_W-1:0]  redirect_pc
);
  br_kind_e   kind;
  fetch_dec_t dec;
  slot_meta_t wr_meta, rd_meta;
  logic       fet_accept, flush_now, late_now, rd_cnt_nz, loop_low_fetch;
  logic [PC_W-1:0] rd_tgt, rd_fall;

  assign kind = br_kind_e'(fet_kind);
  assign dec  = decide_fetch(kind, fet_pred, fet_conf_hi, pred_mode);

  assign fet_taken      = dec.taken;
  assign fet_predicated = dec.low;

  // a fetch beside a flushing resolution is on the wrong path
  assign fet_accept     = fet_valid && !flush_now;
  assign loop_low_fetch = dec.low && (kind == BK_LOOP);

  always_comb begin
    wr_meta           = '0;
    wr_meta.valid     = 1'b1;
    wr_meta.kind      = kind;
    wr_meta.pred      = fet_pred;
    wr_meta.quiet     = dec.low && (kind != BK_LOOP);
    wr_meta.loop_low  = loop_low_fetch;
    wr_meta.exit_seen = loop_low_fetch && !fet_pred;
  end

  wish_mode_flag u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .kill    (flush_now),
    .set_req (fet_accept && dec.set_mode),
    .clr_req (fet_accept && dec.clr_mode),
    .mode    (pred_mode)
  );

  wish_slot_table #(.NSLOT(NSLOT), .PC_W(PC_W), .CNT_W(CNT_W)) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (flush_now),
    .wr_en     (fet_accept),
    .wr_idx    (fet_tag),
    .wr_meta   (wr_meta),
    .wr_tgt    (fet_tgt_pc),
    .wr_fall   (fet_fall_pc),
    .sib_en    (fet_accept && loop_low_fetch),
    .sib_tgt   (fet_tgt_pc),
    .sib_exit  (!fet_pred),
    .sq_en     (late_now),
    .sq_tgt    (rd_tgt),
    .fr_en     (res_valid),
    .fr_idx    (res_tag),
    .rd_idx    (res_tag),
    .rd_meta   (rd_meta),
    .rd_cnt_nz (rd_cnt_nz),
    .rd_tgt    (rd_tgt),
    .rd_fall   (rd_fall)
  );

  wish_resolve_unit #(.PC_W(PC_W)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_taken  (res_taken),
    .meta       (rd_meta),
    .cnt_nz     (rd_cnt_nz),
    .tgt        (rd_tgt),
    .fall       (rd_fall),
    .flush_now  (flush_now),
    .late_now   (late_now),
    .flush_o    (flush),
    .redirect_o (redirect_pc)
  );

  // R2: normal branches follow the predictor
  p_normal_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_valid && fet_kind == 2'b00) |-> (fet_taken == fet_pred));

  // R4: an untrusted wish jump opens a predicated region
  p_mode_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_valid && fet_kind == 2'b01 && !fet_conf_hi && !pred_mode && !flush_now)
      |=> pred_mode);

  // R5: the matching join closes it
  p_join_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_valid && fet_kind == 2'b10 && pred_mode && !flush_now) |=> !pred_mode);

endmodule

// File: tb/wish_fetch_ctrl_test.sv
module wish_fetch_ctrl_test;
  localparam int NS = 8;
  localparam int CMAX = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fet_valid = 1'b0, fet_pred = 1'b0, fet_conf_hi = 1'b0;
  logic [1:0]  fet_kind = 2'b00;
  logic [2:0]  fet_tag = '0, res_tag = '0;
  logic [31:0] fet_tgt_pc = '0, fet_fall_pc = '0;
  logic        res_valid = 1'b0, res_taken = 1'b0;
  logic        fet_taken, fet_predicated, pred_mode, flush;
  logic [31:0] redirect_pc;

  always #4 clk = ~clk;

  wish_fetch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .fet_valid(fet_valid), .fet_kind(fet_kind),
    .fet_pred(fet_pred), .fet_conf_hi(fet_conf_hi), .fet_tag(fet_tag),
    .fet_tgt_pc(fet_tgt_pc), .fet_fall_pc(fet_fall_pc), .res_valid(res_valid),
    .res_tag(res_tag), .res_taken(res_taken), .fet_taken(fet_taken),
    .fet_predicated(fet_predicated), .pred_mode(pred_mode), .flush(flush),
    .redirect_pc(redirect_pc));

  int    checks = 0, errors = 0;
  string req = "R1";

  // reference model state
  bit          mv[NS], mp[NS], mq[NS], ml[NS], me[NS];
  int          mc[NS];
  logic [31:0] mt[NS], mf[NS];
  bit          mmode = 0, mflush = 0;
  logic [31:0] mredir = '0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic mdec(output bit t, output bit l, output bit s, output bit c);
    t = fet_pred; l = 0; s = 0; c = 0;
    if (fet_kind == 2'b01 && (mmode || !fet_conf_hi)) begin t = 0; l = 1; s = !mmode; end
    if (fet_kind == 2'b10 && mmode) begin t = 0; l = 1; c = 1; end
    if (fet_kind == 2'b11) l = !fet_conf_hi;
  endtask

  task automatic mstep();
    bit t, l, s, c;
    int outc, r;
    logic [31:0] lt;
    mdec(t, l, s, c);
    outc = 0; r = int'(res_tag);
    if (res_valid && mv[r] && !mq[r]) begin
      if (ml[r]) begin
        if (res_taken && !mp[r]) outc = 1;
        else if (!res_taken && mp[r]) outc = (me[r] && mc[r] != 0) ? 3 : 2;
      end else if (res_taken != mp[r]) outc = res_taken ? 1 : 2;
    end
    mflush = (outc == 1 || outc == 2);
    if (mflush) begin
      mredir = (outc == 1) ? mt[r] : mf[r];
      mmode = 0;
      for (int i = 0; i < NS; i++) mv[i] = 0;
      return;
    end
    if (fet_valid && s) mmode = 1;
    if (fet_valid && c) mmode = 0;
    if (fet_valid && l && fet_kind == 2'b11)
      for (int i = 0; i < NS; i++)
        if (mv[i] && ml[i] && !me[i] && mt[i] == fet_tgt_pc) begin
          mc[i] = (mc[i] < CMAX) ? mc[i] + 1 : CMAX;
          me[i] = !fet_pred;
        end
    if (res_valid) begin
      lt = mt[r];
      if (outc == 3)
        for (int i = 0; i < NS; i++) if (mv[i] && ml[i] && mt[i] == lt) mv[i] = 0;
      mv[r] = 0;
    end
    if (fet_valid) begin
      r = int'(fet_tag);
      mv[r] = 1; mp[r] = fet_pred; mq[r] = l && fet_kind != 2'b11;
      ml[r] = l && fet_kind == 2'b11; me[r] = ml[r] && !fet_pred;
      mc[r] = 0; mt[r] = fet_tgt_pc; mf[r] = fet_fall_pc;
    end
  endtask

  // inputs were set just after a falling edge
  task automatic tick();
    bit t, l, s, c;
    #1;
    if (fet_valid) begin
      mdec(t, l, s, c);
      chk("fet_taken", 32'(fet_taken), 32'(t));
      chk("fet_predicated", 32'(fet_predicated), 32'(l));
    end
    @(posedge clk);
    mstep();
    @(negedge clk);
    chk("flush", 32'(flush), 32'(mflush));
    chk("pred_mode", 32'(pred_mode), 32'(mmode));
    if (mflush) chk("redirect_pc", redirect_pc, mredir);
    fet_valid = 0; res_valid = 0;
  endtask

  task automatic setf(int tag, logic [1:0] k, bit p, bit ch, logic [31:0] tg, logic [31:0] fa);
    fet_valid = 1; fet_tag = 3'(tag); fet_kind = k; fet_pred = p; fet_conf_hi = ch;
    fet_tgt_pc = tg; fet_fall_pc = fa;
  endtask

  task automatic setr(int tag, bit a);
    res_valid = 1; res_tag = 3'(tag); res_taken = a;
  endtask

  task automatic fet(int tag, logic [1:0] k, bit p, bit ch, logic [31:0] tg, logic [31:0] fa);
    setf(tag, k, p, ch, tg, fa); tick();
  endtask

  task automatic res(int tag, bit a);
    setr(tag, a); tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual hang expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin mv[i] = 0; mc[i] = 0; end
    repeat (3) @(negedge clk);
    req = "R1";
    chk("flush in reset", 32'(flush), 32'd0);
    chk("pred_mode in reset", 32'(pred_mode), 32'd0);
    rst_n = 1;
    idle(2);
    res(3, 1); res(0, 0);                     // R1: nothing tracked

    req = "R2";
    fet(0, 2'b00, 1, 0, 32'h100, 32'h104);    // low conf ignored
    res(0, 0);                                // mispredict -> fall
    idle(1);
    fet(1, 2'b00, 0, 1, 32'h180, 32'h184);
    res(1, 1);                                // mispredict -> target
    fet(2, 2'b00, 1, 1, 32'h1c0, 32'h1c4);
    res(2, 1);                                // correct, no flush

    req = "R3";
    fet(3, 2'b01, 1, 1, 32'h300, 32'h304);
    res(3, 0);
    fet(4, 2'b11, 0, 1, 32'h340, 32'h344);
    res(4, 1);

    req = "R4";
    fet(1, 2'b01, 1, 0, 32'h400, 32'h404);    // forced not-taken, mode set
    res(1, 1);                                // absorbed
    req = "R6";
    fet(2, 2'b01, 1, 1, 32'h480, 32'h484);    // nested, mode stays
    res(2, 0);
    req = "R5";
    fet(3, 2'b10, 1, 0, 32'h4c0, 32'h4c4);    // join clears mode
    res(3, 1);
    fet(5, 2'b10, 1, 1, 32'h500, 32'h504);    // join with mode clear
    res(5, 0);

    req = "R7";
    fet(4, 2'b11, 0, 0, 32'h600, 32'h640);
    res(4, 1);

    req = "R8";
    fet(0, 2'b11, 1, 0, 32'h700, 32'h740);
    fet(1, 2'b11, 1, 0, 32'h700, 32'h740);
    fet(2, 2'b11, 0, 0, 32'h700, 32'h740);
    res(0, 0);                                // late exit, absorbed
    res(1, 0);                                // dropped
    res(2, 0);

    req = "R9";
    fet(0, 2'b11, 1, 0, 32'h800, 32'h840);
    fet(1, 2'b11, 1, 0, 32'h800, 32'h840);
    res(0, 0);                                // no exit -> exit address
    req = "R10";
    res(1, 0);                                // cleared by flush

    fet(5, 2'b01, 0, 0, 32'h900, 32'h904);    // mode on
    fet(6, 2'b00, 1, 1, 32'h940, 32'h944);
    setr(6, 0);
    setf(7, 2'b00, 1, 1, 32'h980, 32'h984);   // discarded fetch
    tick();
    res(7, 0);
    res(5, 1);

    req = "R11";
    fet(3, 2'b00, 0, 1, 32'ha00, 32'ha04);
    res(3, 1);
    res(3, 0);                                // slot gone after flush
    res(6, 1);
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule